// File: doc/BRIEF.md
# General-Purpose Pin Slot Exchange and Interrupt Aggregator

This block sits behind the serial audio link and serves the slot that carries general-purpose pin traffic. In the outbound direction it receives the decoded pin-command field from each frame's slot 12, keeps only the bits that belong to pins configured as outputs, and drives them onto the pins at the following frame boundary. A mode bit hands control of the output pins to a software register instead, and the slot is then ignored.

In the return direction it assembles a 20-bit status word once per frame. The word reports the pin levels (live levels for input pins, the driven value for output pins) and three summary flags. The first flag is a driver-event flag formed from a status register and its enable register. The second is an internal-error flag formed from an error register. The third is an overall interrupt flag. Edges on masked input pins are held in sticky event bits until software clears them.

Top module: `gpio_slot_agg`

## Requirements
- R1: After reset all pin outputs are 0 and the return word is all zeros.
- R2: A command field accepted while `s12_valid` is high reaches an output-configured pin on the first `frame_stb` after it, and not before.
- R3: Command bits for pins configured as inputs (`pin_dir` bit = 0) are discarded. The held command for such a pin keeps its earlier value, which becomes visible when the pin is later made an output.
- R4: A command field presented while `s12_valid` is low changes nothing.
- R5: While `ovr_mode` is 1, output-configured pins follow `ovr_pins` in the same cycle, and slot commands are not accepted. When `ovr_mode` returns to 0, the pins go back to the held command.
- R6: On each `frame_stb` the return word is captured. Its bits 8:4 (bit 4+i for pin i) carry the `pin_in` level for input pins and the currently driven value for output pins. The word holds steady between strobes.
- R7: Return bit 2 is 1 exactly when some bit of `bdi_status` is 1 together with the matching bit of `bdi_enable`.
- R8: Return bit 1 is 1 exactly when any bit of `err_status` is 1.
- R9: A change of level in either direction on an input-configured pin whose `wake_mask` bit is 1 sets that pin's sticky event bit. Unmasked pins and output pins set nothing.
- R10: Return bit 0 is the OR of the sticky events, the driver-event flag and the error flag. A sticky event stays set until a 1 on its own `evt_clr` bit, and clearing another pin's bit leaves it set.
- R11: Return bits 19:9 and bit 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| s12_valid | input | 1 | Decoded slot-12 command field is valid this cycle |
| s12_gpio | input | NPIN (5) | Decoded pin-command field of slot 12 |
| pin_dir | input | NPIN (5) | Direction per pin, 1 = output |
| ovr_mode | input | 1 | 1 = output pins driven from `ovr_pins` |
| ovr_pins | input | NPIN (5) | Register value used in override mode |
| pin_in | input | NPIN (5) | Pin levels from the pads |
| wake_mask | input | NPIN (5) | Per-pin edge-event enable |
| evt_clr | input | NPIN (5) | Per-pin clear pulse for sticky events (software write of 0) |
| bdi_status | input | BDI_W (8) | Driver-event status register |
| bdi_enable | input | BDI_W (8) | Driver-event enable register |
| err_status | input | ERR_W (8) | Internal-error status register |
| pin_out | output | NPIN (5) | Values driven on output pins, 0 on input pins |
| ret_slot | output | 20 | Assembled return slot |

## Verification
The hardest state to reach is a held command that differs from what the pin shows. This happens when a write to an input pin was discarded, or when a write arrived during override and was refused. The bench builds it by first forcing the held command to a known value with every pin set as an output. It then issues a new field under a reduced direction mask or under override, and afterwards widens the direction or leaves override so that the hidden held value appears on `pin_out`. This is swept over every direction mask and every command value.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;
  localparam int SLOT_W   = 20;
  localparam int GPIO_LSB = 4;
  localparam int BDI_BIT  = 2;
  localparam int ERR_BIT  = 1;
  localparam int INT_BIT  = 0;
endpackage

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl #(
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic            s12_valid,
  input  logic [NPIN-1:0] s12_gpio,
  input  logic [NPIN-1:0] pin_dir,
  input  logic            ovr_mode,
  input  logic [NPIN-1:0] ovr_pins,
  output logic [NPIN-1:0] pin_out
);
  // keep bits of input pins, take bits of output pins
  function automatic logic [NPIN-1:0] merge_cmd(input logic [NPIN-1:0] held,
                                                input logic [NPIN-1:0] fresh,
                                                input logic [NPIN-1:0] dir);
    return (held & ~dir) | (fresh & dir);
  endfunction

  logic [NPIN-1:0] pend_q;
  logic [NPIN-1:0] drv_q;
  logic            accept_w;

  assign accept_w = s12_valid && !ovr_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      drv_q  <= '0;
    end else begin
      if (accept_w) pend_q <= merge_cmd(pend_q, s12_gpio, pin_dir);
      if (frame_stb) drv_q <= pend_q;
    end
  end

  assign pin_out = (ovr_mode ? ovr_pins : drv_q) & pin_dir;

  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(drv_q));
  // R3
  in_pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> ((pend_q & ~$past(pin_dir)) == ($past(pend_q) & ~$past(pin_dir))));
  // R4
  no_valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s12_valid |=> $stable(pend_q));
  // R5
  ovr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_mode |=> $stable(pend_q));
endmodule

// File: rtl/gpio_evt_cap.sv
module gpio_evt_cap #(
  parameter int NPIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] wake_mask,
  input  logic [NPIN-1:0] evt_clr,
  output logic [NPIN-1:0] evt_q,
  output logic [NPIN-1:0] edge_w
);
  logic [NPIN-1:0] prev_q;
  logic            primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_in;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign edge_w[i] = primed_q && !pin_dir[i] && wake_mask[i] && (pin_in[i] != prev_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)         evt_q[i] <= 1'b0;
      else if (edge_w[i]) evt_q[i] <= 1'b1;
      else if (evt_clr[i]) evt_q[i] <= 1'b0;
    end

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !evt_clr[i]) |=> evt_q[i]);
    // R9
    out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir[i] && !evt_q[i]) |=> !evt_q[i]);
  end
endmodule

// File: rtl/slot_status_build.sv
module slot_status_build
  import gpio_slot_pkg::*;
#(
  parameter int NPIN  = 5,
  parameter int BDI_W = 8,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [NPIN-1:0]   pin_dir,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   pin_out,
  input  logic [NPIN-1:0]   evt_q,
  input  logic [BDI_W-1:0]  bdi_status,
  input  logic [BDI_W-1:0]  bdi_enable,
  input  logic [ERR_W-1:0]  err_status,
  output logic [SLOT_W-1:0] ret_slot
);
  function automatic logic [SLOT_W-1:0] pack_slot(input logic [NPIN-1:0] lv,
                                                  input logic bdi, input logic err,
                                                  input logic irq);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[GPIO_LSB +: NPIN] = lv;
    w[BDI_BIT] = bdi;
    w[ERR_BIT] = err;
    w[INT_BIT] = irq;
    return w;
  endfunction

  logic [NPIN-1:0] level_w;
  logic            bdi_flag_w;
  logic            err_flag_w;
  logic            irq_flag_w;

  assign level_w    = (pin_in & ~pin_dir) | (pin_out & pin_dir);
  assign bdi_flag_w = |(bdi_status & bdi_enable);
  assign err_flag_w = |err_status;
  assign irq_flag_w = (|evt_q) | bdi_flag_w | err_flag_w;

  always_ff @(posedge clk) begin
    if (!rst_n)         ret_slot <= '0;
    else if (frame_stb) ret_slot <= pack_slot(level_w, bdi_flag_w, err_flag_w, irq_flag_w);
  end

  // R6
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ret_slot));
  // R10
  evt_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (|evt_q)) |=> ret_slot[INT_BIT]);
  // R8
  err_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (|err_status)) |=> (ret_slot[ERR_BIT] && ret_slot[INT_BIT]));
  // R7
  bdi_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (|(bdi_status & bdi_enable))) |=> ret_slot[BDI_BIT]);
endmodule

// File: rtl/gpio_slot_agg.sv
module gpio_slot_agg
  import gpio_slot_pkg::*;
#(
  parameter int NPIN  = 5,
  parameter int BDI_W = 8,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              s12_valid,
  input  logic [NPIN-1:0]   s12_gpio,
  input  logic [NPIN-1:0]   pin_dir,
  input  logic              ovr_mode,
  input  logic [NPIN-1:0]   ovr_pins,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   wake_mask,
  input  logic [NPIN-1:0]   evt_clr,
  input  logic [BDI_W-1:0]  bdi_status,
  input  logic [BDI_W-1:0]  bdi_enable,
  input  logic [ERR_W-1:0]  err_status,
  output logic [NPIN-1:0]   pin_out,
  output logic [SLOT_W-1:0] ret_slot
);
  logic [NPIN-1:0] evt_w;
  logic [NPIN-1:0] edge_w;

  gpio_out_ctl #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .s12_valid(s12_valid),
    .s12_gpio(s12_gpio), .pin_dir(pin_dir), .ovr_mode(ovr_mode),
    .ovr_pins(ovr_pins), .pin_out(pin_out)
  );

  gpio_evt_cap #(.NPIN(NPIN)) u_evt (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .wake_mask(wake_mask), .evt_clr(evt_clr), .evt_q(evt_w), .edge_w(edge_w)
  );

  slot_status_build #(.NPIN(NPIN), .BDI_W(BDI_W), .ERR_W(ERR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .pin_dir(pin_dir),
    .pin_in(pin_in), .pin_out(pin_out), .evt_q(evt_w),
    .bdi_status(bdi_status), .bdi_enable(bdi_enable), .err_status(err_status),
    .ret_slot(ret_slot)
  );

  // R9
  edge_sets_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> (|evt_w));
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (ret_slot[SLOT_W-1:GPIO_LSB+NPIN] == '0 && ret_slot[3] == 1'b0));
endmodule

// File: tb/sim_gpio_slot_agg.sv
module sim_gpio_slot_agg;
  logic clk = 0, rst_n = 0, frame_stb = 0, s12_valid = 0, ovr_mode = 0;
  logic [4:0] s12_gpio = 0, pin_dir = 0, ovr_pins = 0, pin_in = 0, wake_mask = 0, evt_clr = 0;
  logic [7:0] bdi_status = 0, bdi_enable = 0, err_status = 0;
  logic [4:0] pin_out;
  logic [19:0] ret_slot;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_slot_agg u0 (.*);

  task automatic tick(); @(negedge clk); endtask
  task automatic strobe(); frame_stb = 1; tick(); frame_stb = 0; endtask
  task automatic send(input logic [4:0] v);
    s12_gpio = v; s12_valid = 1; tick(); s12_valid = 0; s12_gpio = ~v;
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [4:0] c;
    logic [19:0] exp_w;
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 pin_out", pin_out, 0);
    chk("R1 ret_slot", ret_slot, 0);

    // R2 R3 R4: every direction mask against every command value
    for (int d = 0; d < 32; d++) begin
      for (int v = 0; v < 32; v++) begin
        pin_dir = 5'h1f; send(5'h00); strobe();
        pin_dir = d[4:0]; send(v[4:0]);
        chk("R2 before strobe", pin_out, 0);
        strobe();
        chk("R2 after strobe", pin_out, v[4:0] & d[4:0]);
        pin_dir = 5'h1f; tick();
        chk("R3 input bits discarded", pin_out, v[4:0] & d[4:0]);
        s12_gpio = ~v[4:0]; tick(); strobe();
        chk("R4 no valid no change", pin_out, v[4:0] & d[4:0]);
      end
    end

    // R5 override
    c = 5'b10110;
    for (int d = 0; d < 32; d++) begin
      pin_dir = 5'h1f; send(c); strobe();
      pin_dir = d[4:0]; ovr_mode = 1; ovr_pins = ~d[4:0] ^ 5'b01010; tick();
      chk("R5 follows register", pin_out, (~d[4:0] ^ 5'b01010) & d[4:0]);
      send(~c); strobe();
      chk("R5 slot ignored in override", pin_out, (~d[4:0] ^ 5'b01010) & d[4:0]);
      ovr_mode = 0; pin_dir = 5'h1f; tick();
      chk("R5 back to held", pin_out, c);
      strobe();
      chk("R5 held unchanged", pin_out, c);
    end

    // R6 R11 return word pin field
    pin_dir = 5'h1f; send(c); strobe(); strobe();
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 32; p++) begin
        pin_dir = d[4:0]; pin_in = p[4:0]; tick();
        exp_w = 20'((p[4:0] & ~d[4:0]) | (c & d[4:0])) << 4;
        strobe();
        chk("R6 R11 level field", ret_slot, exp_w);
        pin_in = ~p[4:0]; tick();
        chk("R6 stable between strobes", ret_slot, exp_w);
      end
    end
    pin_in = 0; pin_dir = 0; tick(); strobe();

    // R7 driver-event flag
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        bdi_status = 8'(i * 17); bdi_enable = 8'(j * 13 + 1);
        strobe();
        chk("R7 bdi flag", ret_slot[2], |(bdi_status & bdi_enable));
        chk("R10 irq from bdi", ret_slot[0], |(bdi_status & bdi_enable));
      end
    end
    bdi_status = 0; bdi_enable = 0;

    // R8 error flag
    for (int e = 0; e < 256; e++) begin
      err_status = e[7:0]; strobe();
      chk("R8 err flag", ret_slot[1], e != 0);
      chk("R10 irq from err", ret_slot[0], e != 0);
    end
    err_status = 0;

    // R9 masked edges on input pins, both directions
    pin_dir = 0;
    for (int i = 0; i < 5; i++) begin
      for (int m = 0; m < 32; m++) begin
        wake_mask = m[4:0]; evt_clr = 5'h1f; tick(); evt_clr = 0;
        pin_in[i] = ~pin_in[i]; tick();
        wake_mask = 0; strobe();
        chk("R9 edge event", ret_slot[0], m[i]);
      end
    end
    pin_dir = 5'h1f; wake_mask = 5'h1f; evt_clr = 5'h1f; tick(); evt_clr = 0;
    pin_in = ~pin_in; tick(); strobe();
    chk("R9 output pin no event", ret_slot[0], 0);

    // R10 sticky clear by own bit only
    pin_dir = 0; wake_mask = 5'b00001; tick();
    pin_in[0] = ~pin_in[0]; tick(); wake_mask = 0;
    evt_clr = 5'b00010; tick(); evt_clr = 0; strobe();
    chk("R10 other clear keeps irq", ret_slot[0], 1);
    evt_clr = 5'b00001; tick(); evt_clr = 0; strobe();
    chk("R10 own clear drops irq", ret_slot[0], 0);

    summary();
  end
endmodule